// File: doc/BRIEF.md
# Three-Mode Pulse Output Timer

This block is one channel of a down-counting output timer. A counter and a reload register, both loaded by software, feed a single down-counter. The counter advances only on cycles where the count-clock enable `tick` is high. Each underflow inverts a toggle output and raises a one-cycle interrupt. An underflow is a tick on which the counter already holds zero. A 2-bit mode input selects one of three waveforms. **Single-shot** gives one pulse of reload+1 ticks. **Delayed single-shot** waits counter+1 ticks, then gives one pulse of reload+1 ticks. **Continuous** toggles every reload+1 ticks after an initial wait of counter+1 ticks.

A run starts on a rising edge of the software enable level `en` or on a one-cycle `ext_start` pulse. A falling edge of `en` ends a run at once. The control is a five-state machine:

- **IDLE**: the channel is stopped. A start request moves it to ARM (single-shot), DELAY (delayed) or CONT (continuous).
- **ARM**: the next tick loads the reload value, inverts the output and moves to WIDTH.
- **DELAY**: counts down the counter value. Its underflow loads the reload value and moves to WIDTH.
- **WIDTH**: counts down the pulse width. Its underflow returns to IDLE.
- **CONT**: reloads on every underflow and stays in CONT.

From any running state, a falling edge of `en` returns the machine to IDLE.

Top module: `pulse_timer`

## Requirements
- R1: After reset, `wave`, `irq` and `running` are all 0.
- R2: With mode 2'b00 (single-shot), `wave` inverts on the first tick after the start. It inverts back on tick reload+2 counted from the start. After that tick `running` is 0 and further ticks change nothing.
- R3: Single-shot timing depends only on the reload register. The value written to the counter register has no effect.
- R4: With mode 2'b01 (delayed), `wave` inverts on tick counter+1 and again on tick counter+reload+2. After that `running` is 0 and further ticks change nothing.
- R5: With mode 2'b10 (continuous), `wave` inverts on tick counter+1. After that it inverts every reload+1 ticks for as long as the channel runs.
- R6: `irq` is high for exactly the one clock cycle that follows each underflow, and at no other time. The start inversion in single-shot mode raises no interrupt.
- R7: An `ext_start` pulse starts a run exactly as a rising edge of `en` does.
- R8: A falling edge of `en` clears `running` on the next cycle, even if a tick arrives in the same cycle. `wave` keeps its level, and no `irq` follows.
- R9: A reload write made while the channel runs first affects the next reload. The period already loaded is unchanged.
- R10: On cycles with `tick` low, the counter, `wave` and `irq` do not advance.
- R11: A start request while the channel is running is ignored.
- R12: Mode 2'b11 is reserved. A start request in this mode leaves `running` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count-clock enable, one cycle per count |
| cnt_wr | input | 1 | Write strobe for the counter register |
| cnt_wdata | input | W | Counter write value |
| rld_wr | input | 1 | Write strobe for the reload register |
| rld_wdata | input | W | Reload write value |
| mode | input | 2 | 00 single-shot, 01 delayed, 10 continuous, 11 reserved |
| en | input | 1 | Software enable level: a rise starts a run, a fall stops it |
| ext_start | input | 1 | External start pulse |
| wave | output | 1 | Toggle flip-flop output |
| running | output | 1 | High while a run is in progress |
| irq | output | 1 | One-cycle underflow interrupt |

## Verification
The bench builds the channel with W = 6. This keeps the all-ones reload value (63) reachable in a short run, so the widest single-shot pulse is checked exactly. Zero counter and zero reload values are tested in every mode, including continuous toggling on every tick. Random tick densities spread the counts across idle cycles. A reload write is timed between two underflows of a continuous run.

// File: rtl/pt_pkg.sv
package pt_pkg;
    typedef enum logic [1:0] {
        MODE_ONE   = 2'b00,
        MODE_DELAY = 2'b01,
        MODE_CONT  = 2'b10,
        MODE_NONE  = 2'b11
    } pt_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_DELAY,
        ST_WIDTH,
        ST_CONT
    } pt_state_e;
endpackage

// File: rtl/pt_count.sv
module pt_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    input  logic         rld_wr,
    input  logic [W-1:0] rld_wdata,
    input  logic         ld,
    input  logic         dec,
    output logic         zero
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;
    logic [W-1:0] rld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rld_q <= '0;
        end else begin
            if (rld_wr)
                rld_q <= rld_wdata;
            if (cnt_wr)
                cnt_q <= cnt_wdata;
            else if (ld)
                cnt_q <= rld_q;
            else if (dec)
                cnt_q <= cnt_q - ONE;
        end
    end

    assign zero = (cnt_q == '0);

    // a reload copies the reload register value that held before the edge
    assert_load_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !cnt_wr) |=> (cnt_q == $past(rld_q)));

    // a decrement lowers the counter by exactly one
    assert_dec_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !cnt_wr) |=> (cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/pt_ctrl.sv
module pt_ctrl
    import pt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       en,
    input  logic       ext_start,
    input  logic [1:0] mode,
    input  logic       zero,
    output logic       ld,
    output logic       dec,
    output logic       wave,
    output logic       irq,
    output logic       running
);
    pt_state_e st_q, st_d;
    pt_mode_e  mode_e;
    logic en_q, wave_q, irq_q;
    logic start_req, stop, act, counting, uf, arm_hit;

    assign mode_e    = pt_mode_e'(mode);
    assign start_req = (en & ~en_q) | ext_start;
    assign stop      = ~en & en_q;
    assign act       = tick & ~stop;
    assign counting  = (st_q == ST_DELAY) || (st_q == ST_WIDTH) || (st_q == ST_CONT);
    assign uf        = act & zero & counting;
    assign arm_hit   = act & (st_q == ST_ARM);
    assign ld        = arm_hit | (uf & (st_q != ST_WIDTH));
    assign dec       = act & ~zero & counting;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start_req && !stop) begin
                    unique case (mode_e)
                        MODE_ONE:   st_d = ST_ARM;
                        MODE_DELAY: st_d = ST_DELAY;
                        MODE_CONT:  st_d = ST_CONT;
                        MODE_NONE:  st_d = ST_IDLE;
                        default:    st_d = ST_IDLE;
                    endcase
                end
            end
            ST_ARM:   if (stop) st_d = ST_IDLE; else if (arm_hit) st_d = ST_WIDTH;
            ST_DELAY: if (stop) st_d = ST_IDLE; else if (uf) st_d = ST_WIDTH;
            ST_WIDTH: if (stop || uf) st_d = ST_IDLE;
            ST_CONT:  if (stop) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            en_q <= 1'b0;
        end else begin
            st_q <= st_d;
            en_q <= en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wave_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            wave_q <= wave_q ^ (arm_hit | uf);
            irq_q  <= uf;
        end
    end

    assign wave    = wave_q;
    assign irq     = irq_q;
    assign running = (st_q != ST_IDLE);

    // every interrupt stems from a count-clock tick one cycle earlier
    assert_irq_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(tick));

    // a stopped channel raises no interrupt on the following cycle
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> !irq);

    // the output moves only on an underflow or on the single-shot start load
    assert_wave_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wave) |-> (irq || $past(st_q == ST_ARM)));

    // clearing the enable ends the run on the next cycle
    assert_stop_now_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en) |=> !running);
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    input  logic         rld_wr,
    input  logic [W-1:0] rld_wdata,
    input  logic [1:0]   mode,
    input  logic         en,
    input  logic         ext_start,
    output logic         wave,
    output logic         running,
    output logic         irq
);
    logic ld, dec, zero;

    pt_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .en        (en),
        .ext_start (ext_start),
        .mode      (mode),
        .zero      (zero),
        .ld        (ld),
        .dec       (dec),
        .wave      (wave),
        .irq       (irq),
        .running   (running)
    );

    pt_count #(.W(W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .rld_wr    (rld_wr),
        .rld_wdata (rld_wdata),
        .ld        (ld),
        .dec       (dec),
        .zero      (zero)
    );
endmodule

// File: tb/tb_pulse_timer.sv
`timescale 1ns/1ps
module tb_pulse_timer;
    localparam int W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, cnt_wr = 1'b0, rld_wr = 1'b0, en = 1'b0, ext_start = 1'b0;
    logic [W-1:0] cnt_wdata = '0, rld_wdata = '0;
    logic [1:0] mode = 2'b00;
    logic wave, running, irq;
    int nvec = 0, nbad = 0;

    always #2.5 clk = ~clk;

    pulse_timer #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .rld_wr(rld_wr), .rld_wdata(rld_wdata),
        .mode(mode), .en(en), .ext_start(ext_start),
        .wave(wave), .running(running), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    endtask

    // expected {toggle, irq} on tick number n of a run
    function automatic logic [1:0] exp_event(int md, int n, int c, int r, int r2);
        int base;
        if (md == 0) begin
            if (n == 1) return 2'b10;
            if (n == r + 2) return 2'b11;
            return 2'b00;
        end
        if (md == 1) begin
            if (n == c + 1 || n == c + r + 2) return 2'b11;
            return 2'b00;
        end
        base = c + r + 2;
        if (n == c + 1 || n == base) return 2'b11;
        if (n > base && ((n - base) % (r2 + 1)) == 0) return 2'b11;
        return 2'b00;
    endfunction

    function automatic int exp_last(int md, int c, int r, int r2);
        if (md == 0) return r + 2;
        if (md == 1) return c + r + 2;
        return c + r + 2 + 2 * (r2 + 1);
    endfunction

    task automatic wr_regs(input int c, input int r);
        @(negedge clk);
        cnt_wr = 1'b1; cnt_wdata = c[W-1:0];
        rld_wr = 1'b1; rld_wdata = r[W-1:0];
        @(negedge clk);
        cnt_wr = 1'b0; rld_wr = 1'b0;
    endtask

    task automatic run(input int md, input int c, input int r, input int r2,
                       input bit via_ext, input int pct, input string tag);
        int n, last;
        bit t, wrote, prev;
        logic [1:0] ev;
        wr_regs(c, r);
        mode = md[1:0];
        tick = 1'b0;
        if (via_ext) ext_start = 1'b1; else en = 1'b1;
        prev = wave;
        @(negedge clk);
        ext_start = 1'b0;
        if (via_ext && md == 2) en = 1'b1;   // R11: enable rise mid-run is ignored
        chk(running == 1'b1, via_ext ? "R7" : tag, running, 1);
        n = 0; wrote = 0;
        last = exp_last(md, c, r, r2);
        while (n < last) begin
            rld_wr = 1'b0;
            t = (($urandom % 100) < pct);
            if (md == 2 && n == c + 1 && !wrote) begin
                rld_wr = 1'b1; rld_wdata = r2[W-1:0]; wrote = 1; t = 1'b0;   // R9
            end
            tick = t;
            @(posedge clk); #1;
            if (t) n++;
            ev = t ? exp_event(md, n, c, r, r2) : 2'b00;
            chk((wave != prev) == ev[1], t ? tag : "R10", wave != prev, ev[1]);
            chk(irq == ev[0], "R6", irq, ev[0]);
            chk(running == ((n < last) || md == 2), tag, running, (n < last) || md == 2);
            prev = wave;
            @(negedge clk);
        end
        rld_wr = 1'b0;
        if (md == 2) begin
            en = 1'b0; tick = 1'b1;                 // R8: stop beats same-cycle tick
            @(posedge clk); #1;
            chk(running == 1'b0, "R8", running, 0);
            chk(wave == prev, "R8", wave, prev);
            chk(irq == 1'b0, "R8", irq, 0);
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); tick = 1'b1;
            @(posedge clk); #1;
            chk(wave == prev && !irq && !running, md == 2 ? "R8" : tag, wave, prev);
        end
        @(negedge clk); tick = 1'b0; en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd4242));
        #12;
        chk(wave == 1'b0 && irq == 1'b0 && running == 1'b0, "R1", {wave, irq, running}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wave == 1'b0 && irq == 1'b0 && running == 1'b0, "R1", {wave, irq, running}, 0);

        run(0, 5, 0, 0, 0, 100, "R2");
        run(0, 7, 63, 63, 1, 100, "R3");     // R3: counter value 7 must not matter
        run(1, 0, 0, 0, 0, 100, "R4");
        run(1, 9, 4, 4, 1, 50, "R4");
        run(2, 0, 0, 0, 0, 100, "R5");
        run(2, 2, 3, 6, 1, 100, "R9");
        run(2, 4, 2, 2, 0, 20, "R10");

        // R8: stop a delayed run part way through
        wr_regs(5, 5);
        mode = 2'b01; en = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin tick = 1'b1; @(negedge clk); end
        en = 1'b0; tick = 1'b1;
        @(posedge clk); #1;
        chk(running == 1'b0, "R8", running, 0);
        begin
            bit hold;
            hold = wave;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk); tick = 1'b1;
                @(posedge clk); #1;
                chk(wave == hold && !irq && !running, "R8", wave, hold);
            end
        end
        @(negedge clk); tick = 1'b0;

        // R12: reserved mode never starts
        wr_regs(1, 1);
        mode = 2'b11; en = 1'b1;
        @(negedge clk); ext_start = 1'b1;
        @(negedge clk); ext_start = 1'b0;
        for (int k = 0; k < 4; k++) begin
            tick = 1'b1;
            @(posedge clk); #1;
            chk(!running && !irq, "R12", running, 0);
            @(negedge clk);
        end
        tick = 1'b0; en = 1'b0;
        @(negedge clk);

        for (int i = 0; i < 25; i++) begin
            int md, c, r, r2, pct;
            md = $urandom % 3;
            c = $urandom % 16; r = $urandom % 16; r2 = (md == 2) ? ($urandom % 16) : r;
            pct = 30 + ($urandom % 71);
            run(md, c, r, r2, $urandom % 2,
                pct, md == 0 ? "R2" : (md == 1 ? "R4" : "R5"));
        end

        summary();
        $finish;
    end

    initial begin
        #(5ns * 150000);
        nbad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end
endmodule